// File: doc/BRIEF.md
# Serial Load Register with Latch Decode

This block is the write-only programming port of a dual frequency synthesizer. A host drives three wires: a serial clock, a serial data line and a latch strobe. Each rising edge of the serial clock shifts one data bit into a 22-bit input register. The bits arrive most significant first. A rising edge on the strobe copies the register into one of four holding latches. The two bits shifted in last choose the latch. The four latches hold the side-A reference divider, the side-A feedback divider, the side-B reference divider and the side-B feedback divider.

All three serial wires are asynchronous to the system clock. The block synchronizes them and detects their edges in the system clock domain. A host that can only send whole bytes sends three bytes with the strobe held low, then raises the strobe. The two surplus leading bits fall off the top of the register. For every latch update the block emits a one-cycle pulse tagged with the latch index. It also reports when each of the four latches has been written at least once since reset, which is the condition for enabling the synthesizer outputs.

Top module: `serload_decode`

## Requirements
- R1: After reset all four latch outputs and both reference divider outputs are zero, `all_loaded` is 0 and `upd_valid` is 0.
- R2: Each rising edge of `ser_clk` shifts `ser_data` into bit 0 of a 22-bit register, so data is sent most significant bit first. On a strobe, register bits [21:2] become the 20-bit payload of the selected latch.
- R3: Register bits [1:0] (the last two bits shifted) select the latch: 00 side-A reference, 01 side-A feedback, 10 side-B reference, 11 side-B feedback. The other three latches keep their contents.
- R4: Each reference divider output is bits [13:0] of its side's reference latch payload (register bits [15:2] at load time).
- R5: When more than 22 bits are shifted before a strobe, only the last 22 bits are used.
- R6: `all_loaded` rises only once each of the four latch indices has been written at least once since reset. Repeated writes to the same latch do not count twice, and `all_loaded` stays high until reset.
- R7: Each rising edge of `ser_le` produces exactly one `upd_valid` pulse, one system clock wide, with `upd_idx` equal to the selected latch index. This holds however long `ser_le` stays high.
- R8: Serial clock edges without a strobe leave every latch unchanged and produce no `upd_valid` pulse.
- R9: A word sent as three 8-bit units (24 bits, two leading padding bits) followed by one strobe loads the same latch value as the equivalent 22-bit word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, sampled on serial clock rising edge |
| ser_le | input | 1 | Latch strobe, rising edge transfers the register |
| a_ref_q | output | 20 | Side-A reference latch payload |
| a_fb_q | output | 20 | Side-A feedback latch payload |
| b_ref_q | output | 20 | Side-B reference latch payload |
| b_fb_q | output | 20 | Side-B feedback latch payload |
| a_rdiv | output | 14 | Side-A reference divide ratio |
| b_rdiv | output | 14 | Side-B reference divide ratio |
| all_loaded | output | 1 | All four latches written since reset |
| upd_valid | output | 1 | One-cycle pulse per latch update |
| upd_idx | output | 2 | Index of the latch updated with `upd_valid` |

## Verification
The assertions check on every cycle that:
- the input register moves only on a detected serial clock edge;
- a latch changes only on a detected strobe edge;
- every update pulse follows exactly one strobe edge and lasts one cycle;
- the latch named by the pulse now holds the payload the register had just before the update;
- the loaded flag never drops without reset and only rises together with an update.

Bit order, the effect of surplus bits, byte-wise transfers and the exact point at which the fourth distinct latch raises the loaded flag depend on whole serial sequences. Only the bench's directed scenarios show these, by comparing the latch outputs with words built independently.

// File: rtl/sld_pkg.sv
package sld_pkg;
  localparam int SLD_WORD_W = 22;
  localparam int SLD_CTRL_W = 2;
  localparam int SLD_RDIV_W = 14;
  localparam int SLD_SYNC_N = 2;

  typedef enum logic [1:0] {
    DST_A_REF = 2'd0,
    DST_A_FB  = 2'd1,
    DST_B_REF = 2'd2,
    DST_B_FB  = 2'd3
  } dest_e;
endpackage

// File: rtl/sld_sync.sv
module sld_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din[g]};
    end
    assign dout[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/sld_rise.sv
module sld_rise #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end
  for (genvar g = 0; g < W; g++) begin : g_det
    assign rise[g] = lvl[g] & ~prev[g];
  end
endmodule

// File: rtl/sld_shift_reg.sv
module sld_shift_reg #(
  parameter int WORD_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[WORD_W-2:0], din};
  end
endmodule

// File: rtl/sld_latch_bank.sv
module sld_latch_bank #(
  parameter int WORD_W = 22,
  parameter int CTRL_W = 2,
  localparam int PAY_W = WORD_W - CTRL_W,
  localparam int NLAT  = 1 << CTRL_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [WORD_W-1:0]          word,
  output logic [NLAT-1:0][PAY_W-1:0] lat,
  output logic [NLAT-1:0]            written,
  output logic                       upd_valid,
  output logic [CTRL_W-1:0]          upd_idx
);
  function automatic logic [PAY_W-1:0] f_payload(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:CTRL_W];
  endfunction

  function automatic logic [CTRL_W-1:0] f_dest(input logic [WORD_W-1:0] w);
    return w[CTRL_W-1:0];
  endfunction

  logic [CTRL_W-1:0] dest;
  logic [PAY_W-1:0]  payload;
  assign dest    = f_dest(word);
  assign payload = f_payload(word);

  for (genvar i = 0; i < NLAT; i++) begin : g_lat
    logic hit;
    assign hit = load && (dest == CTRL_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lat[i]     <= '0;
        written[i] <= 1'b0;
      end else if (hit) begin
        lat[i]     <= payload;
        written[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_valid <= 1'b0;
      upd_idx   <= '0;
    end else begin
      upd_valid <= load;
      if (load) upd_idx <= dest;
    end
  end
endmodule

// File: rtl/serload_decode.sv
module serload_decode
  import sld_pkg::*;
#(
  parameter int WORD_W = SLD_WORD_W,
  parameter int CTRL_W = SLD_CTRL_W,
  parameter int RDIV_W = SLD_RDIV_W,
  parameter int SYNC_N = SLD_SYNC_N,
  localparam int PAY_W = WORD_W - CTRL_W,
  localparam int NLAT  = 1 << CTRL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [PAY_W-1:0]  a_ref_q,
  output logic [PAY_W-1:0]  a_fb_q,
  output logic [PAY_W-1:0]  b_ref_q,
  output logic [PAY_W-1:0]  b_fb_q,
  output logic [RDIV_W-1:0] a_rdiv,
  output logic [RDIV_W-1:0] b_rdiv,
  output logic              all_loaded,
  output logic              upd_valid,
  output logic [CTRL_W-1:0] upd_idx
);
  localparam int IDX_A_REF = int'(DST_A_REF);
  localparam int IDX_A_FB  = int'(DST_A_FB);
  localparam int IDX_B_REF = int'(DST_B_REF);
  localparam int IDX_B_FB  = int'(DST_B_FB);

  function automatic logic [RDIV_W-1:0] f_rdiv(input logic [PAY_W-1:0] p);
    return p[RDIV_W-1:0];
  endfunction

  logic [2:0] lvl;
  logic [1:0] rise;
  logic       sclk_rise;
  logic       le_rise;
  logic       data_s;
  logic [WORD_W-1:0]          shift_word;
  logic [NLAT-1:0][PAY_W-1:0] lat;
  logic [NLAT-1:0]            written;

  sld_sync #(.W(3), .STAGES(SYNC_N)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .din ({ser_le, ser_data, ser_clk}),
    .dout(lvl)
  );

  sld_rise #(.W(2)) u_rise (
    .clk (clk),
    .rst_n(rst_n),
    .lvl ({lvl[2], lvl[0]}),
    .rise(rise)
  );

  assign sclk_rise = rise[0];
  assign le_rise   = rise[1];
  assign data_s    = lvl[1];

  sld_shift_reg #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(sclk_rise),
    .din     (data_s),
    .word    (shift_word)
  );

  sld_latch_bank #(.WORD_W(WORD_W), .CTRL_W(CTRL_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (le_rise),
    .word     (shift_word),
    .lat      (lat),
    .written  (written),
    .upd_valid(upd_valid),
    .upd_idx  (upd_idx)
  );

  assign a_ref_q    = lat[IDX_A_REF];
  assign a_fb_q     = lat[IDX_A_FB];
  assign b_ref_q    = lat[IDX_B_REF];
  assign b_fb_q     = lat[IDX_B_FB];
  assign a_rdiv     = f_rdiv(lat[IDX_A_REF]);
  assign b_rdiv     = f_rdiv(lat[IDX_B_REF]);
  assign all_loaded = &written;
endmodule

// File: rtl/sld_check.sv
module sld_check #(
  parameter int WORD_W = 22,
  parameter int CTRL_W = 2,
  parameter int PAY_W  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_rise,
  input logic              le_rise,
  input logic [WORD_W-1:0] shift_word,
  input logic [PAY_W-1:0]  a_ref_q,
  input logic [PAY_W-1:0]  a_fb_q,
  input logic [PAY_W-1:0]  b_ref_q,
  input logic [PAY_W-1:0]  b_fb_q,
  input logic              all_loaded,
  input logic              upd_valid,
  input logic [CTRL_W-1:0] upd_idx
);
  p_shift_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(shift_word));

  p_load_a_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_idx == CTRL_W'(0)) |-> a_ref_q == $past(shift_word[WORD_W-1:CTRL_W]));
  p_load_a_fb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_idx == CTRL_W'(1)) |-> a_fb_q == $past(shift_word[WORD_W-1:CTRL_W]));
  p_load_b_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_idx == CTRL_W'(2)) |-> b_ref_q == $past(shift_word[WORD_W-1:CTRL_W]));
  p_load_b_fb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_idx == CTRL_W'(3)) |-> b_fb_q == $past(shift_word[WORD_W-1:CTRL_W]));

  p_loaded_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    all_loaded |=> all_loaded);
  p_loaded_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(all_loaded) |-> upd_valid);

  p_pulse_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    le_rise |=> upd_valid);
  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $past(le_rise));
  p_pulse_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> !upd_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !le_rise |=> ($stable(a_ref_q) && $stable(a_fb_q) && $stable(b_ref_q) && $stable(b_fb_q)));
endmodule

bind serload_decode sld_check #(
  .WORD_W(WORD_W),
  .CTRL_W(CTRL_W),
  .PAY_W (PAY_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .sclk_rise (sclk_rise),
  .le_rise   (le_rise),
  .shift_word(shift_word),
  .a_ref_q   (a_ref_q),
  .a_fb_q    (a_fb_q),
  .b_ref_q   (b_ref_q),
  .b_fb_q    (b_fb_q),
  .all_loaded(all_loaded),
  .upd_valid (upd_valid),
  .upd_idx   (upd_idx)
);

// File: tb/serload_decode_tb_top.sv
module serload_decode_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [19:0] a_ref_q, a_fb_q, b_ref_q, b_fb_q;
  logic [13:0] a_rdiv, b_rdiv;
  logic all_loaded, upd_valid;
  logic [1:0] upd_idx;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  logic [1:0] last_idx = 2'd0;
  logic [19:0] exp_lat [4];

  always #4 clk = ~clk;

  serload_decode dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .a_ref_q(a_ref_q), .a_fb_q(a_fb_q), .b_ref_q(b_ref_q), .b_fb_q(b_fb_q),
    .a_rdiv(a_rdiv), .b_rdiv(b_rdiv), .all_loaded(all_loaded),
    .upd_valid(upd_valid), .upd_idx(upd_idx)
  );

  always @(negedge clk) begin
    if (rst_n && upd_valid) begin
      pulses <= pulses + 1;
      last_idx <= upd_idx;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ser_clk = 1'b0; ser_data = 1'b0; ser_le = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(3);
    for (int i = 0; i < 4; i++) exp_lat[i] = '0;
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i];
      tick(4);
      ser_clk = 1'b1;
      tick(4);
      ser_clk = 1'b0;
    end
  endtask

  task automatic strobe(input int hold);
    ser_le = 1'b1;
    tick(hold);
    ser_le = 1'b0;
    tick(8);
  endtask

  task automatic write_word(input logic [19:0] pay, input logic [1:0] dst);
    shift_bits({10'b0, pay, dst}, 22);
    strobe(6);
    exp_lat[dst] = pay;
  endtask

  task automatic check_lat(input string req);
    check(req, {12'b0, a_ref_q}, {12'b0, exp_lat[0]});
    check(req, {12'b0, a_fb_q},  {12'b0, exp_lat[1]});
    check(req, {12'b0, b_ref_q}, {12'b0, exp_lat[2]});
    check(req, {12'b0, b_fb_q},  {12'b0, exp_lat[3]});
  endtask

  // R1: reset state
  task automatic t_reset();
    do_reset();
    check_lat("R1");
    check("R1 rdiv", {18'b0, a_rdiv}, 32'd0);
    check("R1 rdiv", {18'b0, b_rdiv}, 32'd0);
    check("R1 loaded", {31'b0, all_loaded}, 32'd0);
    check("R1 valid", {31'b0, upd_valid}, 32'd0);
  endtask

  // R2 R3 R4 R6 R7: each destination in turn
  task automatic t_route();
    logic [19:0] pay [4];
    pay[0] = 20'hA5C3F; pay[1] = 20'h12345; pay[2] = 20'hF0E01; pay[3] = 20'h6789B;
    do_reset();
    for (int d = 0; d < 4; d++) begin
      int p0 = pulses;
      write_word(pay[d], 2'(d));
      check_lat("R2 R3 route");
      check("R7 one pulse", pulses - p0, 32'd1);
      check("R7 idx", {30'b0, last_idx}, d);
      check("R6 loaded", {31'b0, all_loaded}, (d == 3) ? 32'd1 : 32'd0);
    end
    check("R4 a_rdiv", {18'b0, a_rdiv}, {18'b0, pay[0][13:0]});
    check("R4 b_rdiv", {18'b0, b_rdiv}, {18'b0, pay[2][13:0]});
  endtask

  // R6: repeated writes to one latch do not count twice
  task automatic t_partial();
    do_reset();
    write_word(20'h00001, 2'd0);
    write_word(20'h00002, 2'd0);
    write_word(20'h00003, 2'd0);
    write_word(20'h00004, 2'd1);
    write_word(20'h00005, 2'd2);
    check("R6 not yet", {31'b0, all_loaded}, 32'd0);
    write_word(20'h00006, 2'd3);
    check("R6 set", {31'b0, all_loaded}, 32'd1);
    write_word(20'h00007, 2'd1);
    check("R6 sticky", {31'b0, all_loaded}, 32'd1);
    check_lat("R3 partial");
  endtask

  // R5: surplus leading bits are dropped
  task automatic t_overlong();
    shift_bits(32'h7F, 7);
    write_word(20'h3C3C3, 2'd1);
    check_lat("R5");
  endtask

  // R9: three byte-wide units with two padding bits
  task automatic t_bytes();
    logic [19:0] pay = 20'hBEEF1;
    shift_bits({8'b0, 2'b11, pay, 2'b10}, 24);
    strobe(6);
    exp_lat[2] = pay;
    check_lat("R9");
    check("R9 rdiv", {18'b0, b_rdiv}, {18'b0, pay[13:0]});
  endtask

  // R8: shifting without a strobe changes nothing
  task automatic t_no_strobe();
    int p0 = pulses;
    shift_bits({10'b0, 20'hFFFFF, 2'b00}, 22);
    tick(10);
    check_lat("R8");
    check("R8 no pulse", pulses - p0, 32'd0);
  endtask

  // R7: long strobe still one pulse
  task automatic t_long_le();
    int p0 = pulses;
    shift_bits({10'b0, 20'h0F0F0, 2'b11}, 22);
    strobe(40);
    exp_lat[3] = 20'h0F0F0;
    check("R7 long strobe", pulses - p0, 32'd1);
    check("R7 idx", {30'b0, last_idx}, 32'd3);
    check_lat("R7");
  endtask

  initial begin
    t_reset();
    t_route();
    t_partial();
    t_overlong();
    t_bytes();
    t_no_strobe();
    t_long_le();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule